// File: doc/BRIEF.md
# RC Stick Frame Packer

This block turns a set of host-side control-stick values into the byte stream of one over-the-air uplink payload. Each host value is 11 bits wide. On air each stick travels as a 10-bit value, and the block keeps only the upper ten bits. A frame strobe captures the current sticks and mode. The block then emits the payload body one byte per valid/ready handshake. A downstream stage appends the 16-bit CRC, which makes the full 23-byte payload, and passes the result to the radio.

Each frame has eight stick slots. In 8-channel mode the slots hold sticks 0 to 7. In 12-channel mode the first four slots always hold sticks 0 to 3. The other four slots carry sticks 4 to 7 and sticks 8 to 11 on alternate frames, so those sticks update at half rate. A flag in the first byte tells the receiver which group is present. The block returns to the primary group after a reset and after any change of mode.

Top module: `stick_frame_packer`

## Requirements
- R1: Each stick slot carries host bits [10:1] of its source stick, and host bit 0 is dropped without rounding.
- R2: With mode12_i low, slots 0 to 7 carry sticks 0 to 7 and the group flag is 0.
- R3: With mode12_i high, slots 0 to 3 carry sticks 0 to 3, and slots 4 to 7 carry sticks 4 to 7 (flag 0) or sticks 8 to 11 (flag 1). The group alternates on every accepted strobe. The first frame after reset, or after any change of mode12_i, uses sticks 4 to 7.
- R4: Payload byte 0 has bit 5 equal to the group flag, and all its other bits are zero.
- R5: Slot k occupies bits 10k to 10k+9 of an 80-bit field, LSB first. Field bits 8j to 8j+7 form payload byte j+1 for j = 0 to 9. Payload bytes 11 to 20 are zero, and a frame has 21 bytes.
- R6: Exactly one byte advances per cycle in which byte_valid_o and byte_ready_i are both high. While byte_ready_i is low, byte_valid_o and byte_o hold.
- R7: done_o is high for exactly one cycle, in the cycle after the handshake of byte 20. It is never high while byte_valid_o is high.
- R8: A strobe that arrives while a frame is being emitted is ignored. The stream does not restart, and the group does not alternate.
- R9: After reset, byte_valid_o and done_o are low and the group is the primary one.
- R10: The frame content is fixed at the accepted strobe. Later changes to sticks_i or mode12_i do not alter bytes already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sticks_i | input | 132 | Twelve 11-bit host stick values; stick n at bits 11n to 11n+10 |
| mode12_i | input | 1 | 1 selects 12-channel mode, 0 selects 8-channel mode |
| frame_strobe_i | input | 1 | Request to start a frame; taken only when idle |
| byte_o | output | 8 | Current payload byte |
| byte_valid_o | output | 1 | byte_o holds a payload byte |
| byte_ready_i | input | 1 | Consumer accepts byte_o this cycle |
| done_o | output | 1 | One-cycle pulse after the last payload byte |

## Verification
If the group toggle is in the wrong state, the next strobe shows it in byte 0 bit 5, and bytes 6 to 10 then carry the wrong sticks. A toggle that flips on an ignored strobe or misses a mode change shows up on the very next frame. If the byte counter or the shift register is off, the first visible sign is a shifted or truncated stream: either done_o fires at the wrong cycle, or non-zero data appears in the tail bytes within the same frame. A capture error shows as frame bytes that follow sticks_i changed in mid-stream.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int unsigned HOST_W        = 11;
  localparam int unsigned AIR_W         = 10;
  localparam int unsigned N_SLOT        = 8;
  localparam int unsigned N_BASE        = 4;
  localparam int unsigned PAYLOAD_BYTES = 21;
  localparam int unsigned FLAG_BIT      = 5;

  typedef enum logic {
    GRP_PRIMARY = 1'b0,
    GRP_ALT     = 1'b1
  } grp_e;
endpackage

// File: rtl/sfp_group_seq.sv
module sfp_group_seq (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode12_i,
  input  logic          take_i,
  output sfp_pkg::grp_e grp_o
);
  import sfp_pkg::*;

  logic alt_q;
  logic mode_q;
  logic mode_chg;

  assign mode_chg = mode12_i ^ mode_q;
  // a mode change in the strobe cycle already forces the primary group
  assign grp_o = (mode12_i & alt_q & ~mode_chg) ? GRP_ALT : GRP_PRIMARY;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alt_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      mode_q <= mode12_i;
      if (take_i)        alt_q <= mode12_i & (grp_o == GRP_PRIMARY);
      else if (mode_chg) alt_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sfp_slot_map.sv
module sfp_slot_map #(
  parameter int unsigned HOST_W  = sfp_pkg::HOST_W,
  parameter int unsigned AIR_W   = sfp_pkg::AIR_W,
  parameter int unsigned N_SLOT  = sfp_pkg::N_SLOT,
  parameter int unsigned N_BASE  = sfp_pkg::N_BASE,
  localparam int unsigned N_CH    = N_BASE + 2 * (N_SLOT - N_BASE),
  localparam int unsigned FIELD_W = N_SLOT * AIR_W
) (
  input  logic [N_CH*HOST_W-1:0] sticks_i,
  input  sfp_pkg::grp_e          grp_i,
  output logic [FIELD_W-1:0]     field_o
);
  localparam int unsigned DROP = HOST_W - AIR_W;

  logic [N_CH*DROP-1:0] unused_lsbs;

  for (genvar c = 0; c < N_CH; c++) begin : g_lsb
    assign unused_lsbs[c*DROP +: DROP] = sticks_i[c*HOST_W +: DROP];
  end

  for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
    if (k < N_BASE) begin : g_fixed
      assign field_o[k*AIR_W +: AIR_W] = sticks_i[k*HOST_W + DROP +: AIR_W];
    end else begin : g_muxed
      localparam int unsigned ALT_CH = k + (N_SLOT - N_BASE);
      assign field_o[k*AIR_W +: AIR_W] = (grp_i == sfp_pkg::GRP_ALT)
          ? sticks_i[ALT_CH*HOST_W + DROP +: AIR_W]
          : sticks_i[k*HOST_W + DROP +: AIR_W];
    end
  end
endmodule

// File: rtl/sfp_byte_shifter.sv
module sfp_byte_shifter #(
  parameter int unsigned PAYLOAD_BYTES = sfp_pkg::PAYLOAD_BYTES,
  localparam int unsigned PAY_W = PAYLOAD_BYTES * 8,
  localparam int unsigned CNT_W = $clog2(PAYLOAD_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [PAY_W-1:0] payload_i,
  input  logic             ready_i,
  output logic             idle_o,
  output logic             valid_o,
  output logic [7:0]       data_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PAYLOAD_BYTES - 1);

  logic             busy_q;
  logic             done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PAY_W-1:0] pay_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      pay_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (take_i) begin
        pay_q  <= payload_i;
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q && ready_i) begin
        pay_q <= pay_q >> 8;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign idle_o  = ~busy_q;
  assign valid_o = busy_q;
  assign data_o  = pay_q[7:0];
  assign done_o  = done_q;
endmodule

// File: rtl/stick_frame_packer.sv
module stick_frame_packer #(
  parameter int unsigned HOST_W        = sfp_pkg::HOST_W,
  parameter int unsigned AIR_W         = sfp_pkg::AIR_W,
  parameter int unsigned N_SLOT        = sfp_pkg::N_SLOT,
  parameter int unsigned N_BASE        = sfp_pkg::N_BASE,
  parameter int unsigned PAYLOAD_BYTES = sfp_pkg::PAYLOAD_BYTES,
  parameter int unsigned FLAG_BIT      = sfp_pkg::FLAG_BIT,
  localparam int unsigned N_CH = N_BASE + 2 * (N_SLOT - N_BASE)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_CH*HOST_W-1:0] sticks_i,
  input  logic                   mode12_i,
  input  logic                   frame_strobe_i,
  output logic [7:0]             byte_o,
  output logic                   byte_valid_o,
  input  logic                   byte_ready_i,
  output logic                   done_o
);
  localparam int unsigned FIELD_W = N_SLOT * AIR_W;
  localparam int unsigned PAY_W   = PAYLOAD_BYTES * 8;

  sfp_pkg::grp_e      grp;
  logic               idle;
  logic               take;
  logic [FIELD_W-1:0] field;
  logic [PAY_W-1:0]   payload;

  assign take = frame_strobe_i & idle;

  sfp_group_seq u_grp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode12_i(mode12_i),
    .take_i  (take),
    .grp_o   (grp)
  );

  sfp_slot_map #(
    .HOST_W(HOST_W),
    .AIR_W (AIR_W),
    .N_SLOT(N_SLOT),
    .N_BASE(N_BASE)
  ) u_map (
    .sticks_i(sticks_i),
    .grp_i   (grp),
    .field_o (field)
  );

  always_comb begin
    payload           = '0;
    payload[FLAG_BIT] = (grp == sfp_pkg::GRP_ALT);
    payload[8 +: FIELD_W] = field;
  end

  sfp_byte_shifter #(
    .PAYLOAD_BYTES(PAYLOAD_BYTES)
  ) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (take),
    .payload_i(payload),
    .ready_i  (byte_ready_i),
    .idle_o   (idle),
    .valid_o  (byte_valid_o),
    .data_o   (byte_o),
    .done_o   (done_o)
  );
endmodule

// File: rtl/stick_frame_packer_chk.sv
module stick_frame_packer_chk #(
  parameter int unsigned PAYLOAD_BYTES = sfp_pkg::PAYLOAD_BYTES,
  parameter int unsigned FIELD_BYTES   = sfp_pkg::N_SLOT * sfp_pkg::AIR_W / 8,
  parameter int unsigned FLAG_BIT      = sfp_pkg::FLAG_BIT
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_strobe_i,
  input logic [7:0] byte_o,
  input logic       byte_valid_o,
  input logic       byte_ready_i,
  input logic       done_o
);
  localparam int unsigned CNT_W = $clog2(PAYLOAD_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PAYLOAD_BYTES - 1);
  localparam logic [7:0] HDR_MASK = ~(8'h01 << FLAG_BIT);

  logic [CNT_W-1:0] cnt_q;
  logic             fire;

  assign fire = byte_valid_o & byte_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (fire) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  // R6
  hold_on_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o && !byte_ready_i |=> byte_valid_o && $stable(byte_o));

  // R4
  header_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o && cnt_q == '0 |-> (byte_o & HDR_MASK) == 8'h00);

  // R5
  tail_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o && cnt_q > CNT_W'(FIELD_BYTES) |-> byte_o == 8'h00);

  // R7
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !byte_valid_o && $past(fire) && $past(cnt_q) == LAST);

  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  start_from_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(byte_valid_o) |-> $past(frame_strobe_i));

  // R8
  end_at_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(byte_valid_o) |-> $past(fire) && $past(cnt_q) == LAST);
endmodule

bind stick_frame_packer stick_frame_packer_chk #(
  .PAYLOAD_BYTES(PAYLOAD_BYTES),
  .FIELD_BYTES  (N_SLOT * AIR_W / 8),
  .FLAG_BIT     (FLAG_BIT)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_strobe_i(frame_strobe_i),
  .byte_o        (byte_o),
  .byte_valid_o  (byte_valid_o),
  .byte_ready_i  (byte_ready_i),
  .done_o        (done_o)
);

// File: tb/stick_frame_packer_test.sv
`timescale 1ns/1ps
module stick_frame_packer_test;
  localparam int NCH = 12;
  localparam int PB  = 21;

  typedef struct packed {
    logic        mode12;
    logic [10:0] base;
    logic [10:0] step;
    logic        exp_alt;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 11'h7FF, 11'h123, 1'b0},
    '{1'b0, 11'h001, 11'h0AA, 1'b0},
    '{1'b1, 11'h400, 11'h055, 1'b0},
    '{1'b1, 11'h3FF, 11'h101, 1'b1},
    '{1'b1, 11'h000, 11'h7FF, 1'b0},
    '{1'b1, 11'h555, 11'h222, 1'b1},
    '{1'b0, 11'h2AA, 11'h013, 1'b0},
    '{1'b1, 11'h7FE, 11'h004, 1'b0}
  };

  logic                  clk = 1'b0;
  logic                  rst_ni = 1'b0;
  logic [NCH-1:0][10:0]  cur = '0;
  logic                  mode12 = 1'b0;
  logic                  strobe = 1'b0;
  logic                  ready = 1'b0;
  logic [7:0]            byte_o;
  logic                  byte_valid_o;
  logic                  done_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  stick_frame_packer uut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .sticks_i      (cur),
    .mode12_i      (mode12),
    .frame_strobe_i(strobe),
    .byte_o        (byte_o),
    .byte_valid_o  (byte_valid_o),
    .byte_ready_i  (ready),
    .done_o        (done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // R1 R2 R3 R4 R5 model
  function automatic logic [7:0] exp_byte(input logic m12, input logic alt,
                                          input logic [NCH-1:0][10:0] s, input int idx);
    logic [79:0] f;
    f = '0;
    for (int k = 0; k < 8; k++) begin
      int src;
      src = (m12 && alt && k >= 4) ? k + 4 : k;
      f[k*10 +: 10] = s[src][10:1];
    end
    if (idx == 0) return alt ? 8'h20 : 8'h00;
    if (idx <= 10) return f[(idx-1)*8 +: 8];
    return 8'h00;
  endfunction

  task automatic run_frame(input logic m12, input logic exp_alt, input int rpat,
                           input bit mid_strobe, input string tag);
    logic [NCH-1:0][10:0] snap;
    logic [7:0] got_b [PB];
    int got;
    int cyc;
    int bad;
    @(negedge clk);
    mode12 = m12;
    strobe = 1'b1;
    snap   = cur;
    @(negedge clk);
    strobe = 1'b0;
    got = 0;
    cyc = 0;
    bad = 0;
    while (got < PB && cyc < 400) begin
      ready = (rpat == 0) ? 1'b1 : ((cyc % 3) != 1);
      if (done_o) bad++;
      if (mid_strobe && cyc == 5) begin
        strobe = 1'b1;
        mode12 = ~m12;
        for (int c = 0; c < NCH; c++) cur[c] = ~cur[c];
      end else begin
        strobe = 1'b0;
      end
      if (byte_valid_o && ready) begin
        got_b[got] = byte_o;
        got++;
      end
      @(negedge clk);
      cyc++;
    end
    ready  = 1'b0;
    strobe = 1'b0;
    check(got == PB, {"R5 byte count ", tag}, got, PB);
    check(bad == 0, {"R7 early done ", tag}, bad, 0);
    check(done_o === 1'b1 && byte_valid_o === 1'b0, {"R7 done pulse ", tag},
          {done_o, byte_valid_o}, 2'b10);
    for (int i = 0; i < PB; i++) begin
      logic [7:0] e;
      e = exp_byte(m12, exp_alt, snap, i);
      check(got_b[i] === e, $sformatf("R3 R5 R10 %s byte %0d", tag, i), got_b[i], e);
    end
    check(got_b[0][5] === exp_alt, {"R4 group flag ", tag}, got_b[0][5], exp_alt);
    @(negedge clk);
    check(done_o === 1'b0, {"R7 done width ", tag}, done_o, 0);
    check(byte_valid_o === 1'b0, {"R8 no restart ", tag}, byte_valid_o, 0);
    if (mid_strobe) begin
      mode12 = m12;
      for (int c = 0; c < NCH; c++) cur[c] = ~cur[c];
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R9
    check(byte_valid_o === 1'b0, "R9 valid after reset", byte_valid_o, 0);
    check(done_o === 1'b0, "R9 done after reset", done_o, 0);

    for (int v = 0; v < 8; v++) begin
      for (int c = 0; c < NCH; c++) cur[c] = VECS[v].base + VECS[v].step * 11'(c);
      run_frame(VECS[v].mode12, VECS[v].exp_alt, v % 2, 1'b0, $sformatf("vec%0d", v));
    end

    // R8 R10: strobe and stick change mid-stream, group toggle now alt
    for (int c = 0; c < NCH; c++) cur[c] = 11'h0F0 + 11'(c * 97);
    run_frame(1'b1, 1'b1, 1, 1'b1, "mid strobe");
    run_frame(1'b1, 1'b0, 0, 1'b0, "after ignored strobe");

    // R3: mode change without strobe resets the toggle
    repeat (2) @(negedge clk);
    mode12 = 1'b0;
    repeat (3) @(negedge clk);
    mode12 = 1'b1;
    repeat (2) @(negedge clk);
    run_frame(1'b1, 1'b0, 1, 1'b0, "mode change");

    // R9: reset returns to the primary group
    run_frame(1'b1, 1'b1, 0, 1'b0, "pre reset");
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    check(byte_valid_o === 1'b0, "R9 valid in reset", byte_valid_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    run_frame(1'b1, 1'b0, 0, 1'b0, "post reset");

    // R1: extreme host values
    for (int c = 0; c < NCH; c++) cur[c] = (c % 2) ? 11'h001 : 11'h7FF;
    run_frame(1'b0, 1'b0, 1, 1'b0, "truncation");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule